// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

The block is a GPIO port of configurable width behind a minimal strobe-based register bus. Software loads an output latch, either as a whole word or through atomic set and clear writes, and chooses for each pin whether it is driven. The pin side presents an output-value vector and an output-enable vector, and it samples an input vector through a two-flop synchronizer. Software reads the synchronized pin levels back through the data register.

Four build-time choices adapt the port to the surrounding system. The first is the sense of the direction register: a 1 can mean "drive" or "receive". The second is whether pin numbers run in reverse bit order. The third is whether bus words arrive byte-swapped. The fourth is whether the set register reads back the output latch. Software can use that readback for pins it drives and the data register for pins it receives.

Top module: `gpio_port_ctrl`

## Requirements
- R1: `WIDTH` is 8, 16, 32 or 64, and the port has exactly `WIDTH` pins. Any other width is rejected at elaboration. Byte swapping is rejected at elaboration unless `WIDTH` is 16 or 32.
- R2: A write to word offset 0 (data) replaces the whole output latch. From the clock edge that takes the write, `pin_out` shows the new latch value.
- R3: A read of offset 0 returns the pin levels after a two-flop synchronizer. If `pin_in` changes before edge k, a read strobe taken at edge k+1 still returns the old level, and a read strobe taken at edge k+2 returns the new level.
- R4: A write to offset 1 (set) drives to 1 each latch bit whose write bit is 1. Latch bits whose write bit is 0 keep their value.
- R5: A write to offset 2 (clear) drives to 0 each latch bit whose write bit is 1. Latch bits whose write bit is 0 keep their value. A read of offset 2 always returns 0.
- R6: Offset 3 holds the direction register and reads back as it was written. With `DIR_IS_INPUT`=0, a 1 bit enables the output of its pin. With `DIR_IS_INPUT`=1, a 1 bit makes its pin an input, so that pin's `pin_oe` is 0.
- R7: After reset, the latch is zero and every pin is an input, so `pin_out` and `pin_oe` are all zeros. The direction register reads back all zeros when `DIR_IS_INPUT`=0 and all ones when it is 1. `bus_rdata` is zero.
- R8: With `BIT_REVERSE`=1, pin n corresponds to register bit `WIDTH-1-n`, for output, enable and input alike. With `BIT_REVERSE`=0, pin n corresponds to register bit n.
- R9: With `BYTE_SWAP`=1, byte k of the bus word corresponds to byte `WIDTH/8-1-k` of the register, on both writes and reads.
- R10: A read of offset 1 returns the output latch when `SET_READBACK`=1 and returns 0 otherwise.
- R11: `bus_rdata` is loaded at a clock edge where `bus_sel`=1 and `bus_wr`=0. At all other edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset: 0 data, 1 set, 2 clear, 3 direction |
| bus_wdata | input | WIDTH | Write data, in bus byte order |
| bus_rdata | output | WIDTH | Registered read data, in bus byte order |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output value of each pin |
| pin_oe | output | WIDTH | Output enable of each pin |

## Verification
Two instances run side by side. One uses plain numbering with a 1-means-output direction register. The other is 16 bits wide and uses byte swapping, bit reversal, the inverted direction sense, and no set readback. A mapping bug therefore shows up as a mirrored or byte-exchanged `pin_out` or readback. A wrong polarity shows up as enables on pins that should be inputs, or as a reset that leaves pins driven. The set and clear tests mix 0 and 1 write bits, so a design that wrote the word straight into the latch would clobber the untouched bits. The synchronizer latency is probed one edge early and at the expected edge, which catches a missing or extra flop stage.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int GPIO_ADDR_W = 2;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        REG_DATA  = 2'd0,
        REG_SET   = 2'd1,
        REG_CLEAR = 2'd2,
        REG_DIR   = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_byte_order.sv
module gpio_byte_order #(
    parameter int WIDTH = 32,
    parameter int SWAP  = 0
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NBYTES = WIDTH / 8;

    generate
        if (SWAP != 0) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
    parameter int WIDTH   = 32,
    parameter int REVERSE = 0
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (REVERSE != 0) begin : g_rev
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign dout[i] = din[WIDTH-1-i];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_in;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.stage2;

    // R3: the visible level is the input from two edges back
    a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sync_q.stage2 == $past(sync_q.stage1)));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int DIR_IS_INPUT = 0,
    parameter int BIT_REVERSE  = 0,
    parameter int BYTE_SWAP    = 0,
    parameter int SET_READBACK = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]       bus_wdata,
    output logic [WIDTH-1:0]       bus_rdata,
    input  logic [WIDTH-1:0]       pin_in,
    output logic [WIDTH-1:0]       pin_out,
    output logic [WIDTH-1:0]       pin_oe
);
    localparam logic [WIDTH-1:0] DIR_RST = (DIR_IS_INPUT != 0) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    // R1: elaboration-time parameter checks
    generate
        if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
            $error("gpio_port_ctrl: WIDTH must be 8, 16, 32 or 64");
        end
        if (BYTE_SWAP != 0 && !(WIDTH == 16 || WIDTH == 32)) begin : g_bad_swap
            $error("gpio_port_ctrl: byte swap needs WIDTH 16 or 32");
        end
    endgenerate

    typedef struct packed {
        logic [WIDTH-1:0] latch;   // register bit order
        logic [WIDTH-1:0] dir;     // register bit order
        logic [WIDTH-1:0] rdata;   // bus byte order
    } port_state_t;

    port_state_t st_d, st_q;

    logic [WIDTH-1:0] wr_word;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] in_word;
    logic [WIDTH-1:0] rd_word;
    logic [WIDTH-1:0] rd_bus;
    logic [WIDTH-1:0] oe_word;

    gpio_byte_order #(.WIDTH(WIDTH), .SWAP(BYTE_SWAP)) u_wr_order (
        .din  (bus_wdata),
        .dout (wr_word)
    );

    gpio_byte_order #(.WIDTH(WIDTH), .SWAP(BYTE_SWAP)) u_rd_order (
        .din  (rd_word),
        .dout (rd_bus)
    );

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_in_map (
        .din  (pin_sync),
        .dout (in_word)
    );

    gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_out_map (
        .din  (st_q.latch),
        .dout (pin_out)
    );

    gpio_bit_order #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_oe_map (
        .din  (oe_word),
        .dout (pin_oe)
    );

    generate
        if (DIR_IS_INPUT != 0) begin : g_dir_in
            assign oe_word = ~st_q.dir;
        end else begin : g_dir_out
            assign oe_word = st_q.dir;
        end
    endgenerate

    always_comb begin
        case (gpio_reg_e'(bus_addr))
            REG_DATA:  rd_word = in_word;
            REG_SET:   rd_word = (SET_READBACK != 0) ? st_q.latch : '0;
            REG_CLEAR: rd_word = '0;
            REG_DIR:   rd_word = st_q.dir;
            default:   rd_word = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (bus_sel) begin
            if (bus_wr) begin
                case (gpio_reg_e'(bus_addr))
                    REG_DATA:  st_d.latch = wr_word;
                    REG_SET:   st_d.latch = st_q.latch | wr_word;
                    REG_CLEAR: st_d.latch = st_q.latch & ~wr_word;
                    REG_DIR:   st_d.dir   = wr_word;
                    default:   st_d = st_q;
                endcase
            end else begin
                st_d.rdata = rd_bus;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '0;
            st_q.dir   <= DIR_RST;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    logic wr_set, wr_clr, wr_latch, wr_dir, rd_any;
    assign wr_set   = bus_sel && bus_wr && (bus_addr == REG_SET);
    assign wr_clr   = bus_sel && bus_wr && (bus_addr == REG_CLEAR);
    assign wr_latch = bus_sel && bus_wr && (bus_addr != REG_DIR);
    assign wr_dir   = bus_sel && bus_wr && (bus_addr == REG_DIR);
    assign rd_any   = bus_sel && !bus_wr;

    // R4: a set write never clears a latch bit
    a_r4_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((st_q.latch & $past(st_q.latch)) == $past(st_q.latch)));

    // R5: a clear write never raises a latch bit
    a_r5_clear_no_new_ones: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((st_q.latch & ~$past(st_q.latch)) == '0));

    // R2: the pin outputs change only after a latch write
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_latch |=> $stable(pin_out));

    // R6: the enables change only after a direction write
    a_r6_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

    // R11: read data holds between reads
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> $stable(bus_rdata));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] pins = '0;
    logic [31:0] rdata_a, out_a, oe_a;
    logic [15:0] rdata_b, out_b, oe_b;

    always #4 clk = ~clk;

    // Plain instance: 32 bits, 1 = output, natural order, set readback on
    gpio_port_ctrl #(.WIDTH(32), .DIR_IS_INPUT(0), .BIT_REVERSE(0),
                     .BYTE_SWAP(0), .SET_READBACK(1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .pin_in(pins),
        .pin_out(out_a), .pin_oe(oe_a)
    );

    // Variant instance: 16 bits, 1 = input, reversed pins, swapped bytes
    gpio_port_ctrl #(.WIDTH(16), .DIR_IS_INPUT(1), .BIT_REVERSE(1),
                     .BYTE_SWAP(1), .SET_READBACK(0)) dut_b (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata[15:0]), .bus_rdata(rdata_b), .pin_in(pins[15:0]),
        .pin_out(out_b), .pin_oe(oe_b)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] exp;
        int          which;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic  rd_pend = 1'b0;

    // Model state: latch and direction in register order
    logic [31:0] m_la, m_da;
    logic [15:0] m_lb, m_db;

    function automatic logic [15:0] swap16(input logic [15:0] x);
        return {x[7:0], x[15:8]};
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] x);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = x[15-i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [31:0] ea,
                            input logic [15:0] eb, input string tag);
        item_t it;
        it.exp = ea; it.which = 0; it.tag = {tag, " (plain)"};
        sb_q.push_back(it);
        it.exp = {16'h0, eb}; it.which = 1; it.tag = {tag, " (variant)"};
        sb_q.push_back(it);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic check_pins(input string tag);
        check({tag, " pin_out plain"},   out_a, m_la);
        check({tag, " pin_out variant"}, {16'h0, out_b}, {16'h0, rev16(m_lb)});
        check({tag, " pin_oe plain"},    oe_a, m_da);
        check({tag, " pin_oe variant"},  {16'h0, oe_b}, {16'h0, rev16(~m_db)});
    endtask

    // Monitor: a read taken at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_pend <= sel && !wr && rst_n;

    always @(negedge clk) begin
        if (rd_pend) begin
            repeat (2) begin
                if (sb_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R11: read with no expected item, actual %h expected item", rdata_a);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (it.which == 0) check(it.tag, rdata_a, it.exp);
                    else               check(it.tag, {16'h0, rdata_b}, it.exp);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_la = '0; m_da = '0; m_lb = '0; m_db = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 rdata plain", rdata_a, 32'h0);
        check("R7 rdata variant", {16'h0, rdata_b}, 32'h0);
        check_pins("R7 reset");
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd3, 32'h0, 16'hFFFF, "R7 R6 dir after reset");
        bus_read(2'd0, 32'h0, 16'h0, "R7 data after reset");

        // R2 R9 R8: whole-word data write
        bus_write(2'd0, 32'hA5A5_0F1E);
        m_la = 32'hA5A5_0F1E; m_lb = swap16(16'h0F1E);
        check_pins("R2 R8 R9 data write");

        // R4: set with mixed bits
        bus_write(2'd1, 32'h0000_30C1);
        m_la = m_la | 32'h0000_30C1; m_lb = m_lb | swap16(16'h30C1);
        check_pins("R4 set write");

        // R5: clear with mixed bits
        bus_write(2'd2, 32'h0F00_0016);
        m_la = m_la & ~32'h0F00_0016; m_lb = m_lb & ~swap16(16'h0016);
        check_pins("R5 clear write");

        // R4: set with no ones leaves latch alone
        bus_write(2'd1, 32'h0);
        check_pins("R4 zero set");

        // R10 R5: readback of set and clear offsets
        bus_read(2'd1, m_la, 16'h0, "R10 set readback");
        bus_read(2'd2, 32'h0, 16'h0, "R5 clear reads zero");

        // R6: direction polarity
        bus_write(2'd3, 32'hFFFF_0000);
        m_da = 32'hFFFF_0000; m_db = swap16(16'h0000);
        check_pins("R6 dir write 1");
        bus_write(2'd3, 32'h00FF_0001);
        m_da = 32'h00FF_0001; m_db = swap16(16'h0001);
        check_pins("R6 R8 R9 dir write 2");
        bus_read(2'd3, m_da, swap16(m_db), "R6 dir readback");

        // R3 R8 R9: synchronized input readback
        pins = 32'h1234_8001;
        repeat (3) @(negedge clk);
        bus_read(2'd0, 32'h1234_8001, swap16(rev16(16'h8001)), "R3 R8 R9 pin read");

        // R3: latency of the synchronizer
        pins = 32'hCAFE_3C5A;
        @(negedge clk);
        bus_read(2'd0, 32'h1234_8001, swap16(rev16(16'h8001)), "R3 one edge early");
        bus_read(2'd0, 32'hCAFE_3C5A, swap16(rev16(16'h3C5A)), "R3 at latency");

        // R11: read data holds across writes
        bus_write(2'd0, 32'h0000_0000);
        m_la = '0; m_lb = '0;
        @(negedge clk);
        check("R11 rdata hold plain", rdata_a, 32'hCAFE_3C5A);
        check("R11 rdata hold variant", {16'h0, rdata_b}, {16'h0, swap16(rev16(16'h3C5A))});
        check_pins("R2 R1 final");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule